// File: doc/BRIEF.md
# SPI Slave Command Decoder with Readiness Reply

This block is the target side of an SPI link, working in clock mode 0 (SCLK idles low, both sides sample on the rising edge and change data after the falling edge). Every transaction opens with a command byte. The decoder uses that byte to choose one of four paths. The first path answers a status query with a readiness byte. The second and third run an address phase followed by a data phase, either receiving write data or sending read data. The last path goes silent for command codes it does not serve. The command byte can select dual-lane address, dual-lane data and a dummy gap before read data.

The SCLK, CSn and lane pins are oversampled by the local clock through a synchronizer, so SCLK high and low times must each be at least six local clock periods. The surrounding logic sees the following:
- a level input that says whether the block is ready;
- the last command byte, with a one-cycle pulse when it arrives;
- the captured address;
- a received-byte stream;
- a transmit-byte stream that the block pulls one byte at a time.

Lane 0 is the master-to-slave line in single mode. Lane 1 is the slave-to-master line. In dual mode each SCLK period carries two bits, and lane 1 holds the more significant bit of the pair.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, lane enables, last command, address, received byte, the command pulse, the receive strobe and the pull strobe are all zero.
- R2: The command byte is taken MSB first from lane 0 on eight SCLK rising edges after CSn falls. After the eighth edge `last_cmd_o` holds the byte and `cmd_irq_o` is high for exactly one clock. `last_cmd_o` changes at no other time.
- R3: Code 0x05 is a single-lane status query and 0x15 is a dual-lane one. Each byte clocked out while CSn stays low is 0x5A if `ready_i` is high and 0x00 if it is low. A status query never asserts `tx_pop_o`.
- R4: Four fixed data codes exist. 0x0B is a single-lane read and 0x0C a read with dual-lane data. 0x51 is a single-lane write and 0x52 a write with dual-lane data. None of them uses a dual-lane address or a dummy gap.
- R5: Any other code except those in R9 is decoded from flag bits. Bit 7 set means read and clear means write. Bit 6 selects a dual-lane address and bit 5 dual-lane data. Bit 4 inserts DUMMY_CYCLES (default 4) idle SCLK periods before read data and has no effect on writes.
- R6: The address phase is ADDR_W bits (default 16), MSB first. `addr_o` takes the full value once the last address bit arrives.
- R7: Write data is taken MSB first. Each complete byte gives one `rx_valid_o` pulse with the byte on `rx_data_o`. A partial byte is discarded.
- R8: Read data comes from `tx_data_i`. The block samples it, with a one-clock `tx_pop_o`, on each SCLK falling edge that starts a byte. This includes the falling edge after the last full byte. In single mode the lane enables read 2'b10 and the data goes on lane 1. In dual mode they read 2'b11.
- R9: Codes 0x25, 0x0E and 0x54 still update `last_cmd_o` and pulse `cmd_irq_o`. After that, until CSn rises, the block drives no lane, captures no address and emits no received byte or pull strobe.
- R10: A rising CSn ends any phase. The lane enables drop within three clocks, and the next falling CSn expects a new command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | SPI clock from master |
| spi_csn_i | input | 1 | Active-low select from master |
| spi_io_i | input | 2 | Lane inputs (lane 0 = master data in single mode) |
| spi_io_o | output | 2 | Lane output values |
| spi_io_oe_o | output | 2 | Lane output enables |
| ready_i | input | 1 | Readiness level reported by status queries |
| last_cmd_o | output | 8 | Last command byte received |
| cmd_irq_o | output | 1 | One-clock pulse when a command byte arrives |
| addr_o | output | ADDR_W | Captured address |
| rx_data_o | output | 8 | Received write byte |
| rx_valid_o | output | 1 | Strobe for `rx_data_o` |
| tx_data_i | input | 8 | Next read byte to send |
| tx_pop_o | output | 1 | Strobe: `tx_data_i` has been taken |

## Verification
Some properties are checked on every clock. One is that the lane enables fall once the synchronized select is high. Others are that the command pulse lasts one clock and is the only moment the stored command changes, that the pull strobe appears only on read commands, that received bytes appear only on write commands, and that an unserved command stays silent. The bench scenarios are the only way to show the data itself. That covers the bit order and lane split of address and data, the readiness byte following the level input, and the dummy gap shifting read data by the right number of SCLK periods. It also covers the effect of an abort on a partly received byte and the prefetch on the final falling edge.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [1:0] {
    K_SILENT = 2'd0,
    K_STATUS = 2'd1,
    K_READ   = 2'd2,
    K_WRITE  = 2'd3
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e kind;
    logic      dual_addr;
    logic      dual_data;
    logic      dummy;
  } cmd_dec_t;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_TXD   = 3'd4,
    PH_RXD   = 3'd5,
    PH_HALT  = 3'd6
  } phase_e;

  localparam logic [7:0] READY_BYTE = 8'h5A;
  localparam logic [7:0] BUSY_BYTE  = 8'h00;

  // Fixed codes take priority over the flag-bit decode.
  function automatic cmd_dec_t decode_cmd(input logic [7:0] c);
    cmd_dec_t d;
    d.kind      = c[7] ? K_READ : K_WRITE;
    d.dual_addr = c[6];
    d.dual_data = c[5];
    d.dummy     = c[7] & c[4];
    case (c)
      8'h05: d = '{kind: K_STATUS, dual_addr: 1'b0, dual_data: 1'b0, dummy: 1'b0};
      8'h15: d = '{kind: K_STATUS, dual_addr: 1'b0, dual_data: 1'b1, dummy: 1'b0};
      8'h25, 8'h0E, 8'h54:
             d = '{kind: K_SILENT, dual_addr: 1'b0, dual_data: 1'b0, dummy: 1'b0};
      8'h0B: d = '{kind: K_READ,   dual_addr: 1'b0, dual_data: 1'b0, dummy: 1'b0};
      8'h0C: d = '{kind: K_READ,   dual_addr: 1'b0, dual_data: 1'b1, dummy: 1'b0};
      8'h51: d = '{kind: K_WRITE,  dual_addr: 1'b0, dual_data: 1'b0, dummy: 1'b0};
      8'h52: d = '{kind: K_WRITE,  dual_addr: 1'b0, dual_data: 1'b1, dummy: 1'b0};
      default: ;
    endcase
    return d;
  endfunction

  function automatic logic [7:0] status_byte(input logic ready);
    return ready ? READY_BYTE : BUSY_BYTE;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
    end else begin
      st_q[0] <= d;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/spi_tx_serializer.sv
module spi_tx_serializer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       active,
  input  logic       fall,
  input  logic       dual,
  input  logic [7:0] next_byte,
  output logic [1:0] io_out,
  output logic [1:0] io_oe,
  output logic       load
);
  logic [7:0] sh_q;
  logic [3:0] left_q;

  assign load = active & fall & (left_q == 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      io_out <= '0;
      io_oe  <= '0;
    end else if (clear) begin
      sh_q   <= '0;
      left_q <= '0;
      io_out <= '0;
      io_oe  <= '0;
    end else if (active && fall) begin
      io_oe <= dual ? 2'b11 : 2'b10;
      if (left_q == 4'd0) begin
        if (dual) begin
          io_out <= next_byte[7:6];
          sh_q   <= {next_byte[5:0], 2'b00};
          left_q <= 4'd6;
        end else begin
          io_out <= {next_byte[7], 1'b0};
          sh_q   <= {next_byte[6:0], 1'b0};
          left_q <= 4'd7;
        end
      end else if (dual) begin
        io_out <= sh_q[7:6];
        sh_q   <= {sh_q[5:0], 2'b00};
        left_q <= left_q - 4'd2;
      end else begin
        io_out <= {sh_q[7], 1'b0};
        sh_q   <= {sh_q[6:0], 1'b0};
        left_q <= left_q - 4'd1;
      end
    end
  end

  AST_OE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 2'b00) || (io_oe == 2'b10) || (io_oe == 2'b11)); // R8
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int DUMMY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk_i,
  input  logic              spi_csn_i,
  input  logic [1:0]        spi_io_i,
  output logic [1:0]        spi_io_o,
  output logic [1:0]        spi_io_oe_o,
  input  logic              ready_i,
  output logic [7:0]        last_cmd_o,
  output logic              cmd_irq_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        rx_data_o,
  output logic              rx_valid_o,
  input  logic [7:0]        tx_data_i,
  output logic              tx_pop_o
);
  localparam int SH_W  = (ADDR_W > 8) ? ADDR_W : 8;
  localparam int CNT_W = $clog2(SH_W + DUMMY_CYCLES + 1) + 1;

  // Synchronized pins: {sclk, csn, io1, io0}
  logic [3:0] pins_s;
  logic       sclk_s, csn_s;
  logic [1:0] io_s;

  spi_pin_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_sclk_i, spi_csn_i, spi_io_i}),
    .q     (pins_s)
  );

  assign sclk_s = pins_s[3];
  assign csn_s  = pins_s[2];
  assign io_s   = pins_s[1:0];

  logic sclk_rise, sclk_fall;

  spi_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (sclk_s),
    .rise  (sclk_rise),
    .fall  (sclk_fall)
  );

  phase_e           phase_q;
  cmd_dec_t         dec_q;
  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] cnt_q;

  // Internal events, named for the assertions
  logic             lane_dual;
  logic [SH_W-1:0]  shift_nxt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cmd_done, addr_done, byte_in_done, dummy_done;
  logic [7:0]       cmd_byte;
  cmd_dec_t         new_dec;

  always_comb begin
    case (phase_q)
      PH_ADDR: lane_dual = dec_q.dual_addr;
      PH_RXD:  lane_dual = dec_q.dual_data;
      default: lane_dual = 1'b0;
    endcase
  end

  assign shift_nxt = lane_dual ? {sh_q[SH_W-3:0], io_s[1], io_s[0]}
                               : {sh_q[SH_W-2:0], io_s[0]};
  assign cnt_nxt   = cnt_q + (lane_dual ? CNT_W'(2) : CNT_W'(1));
  assign cmd_byte  = shift_nxt[7:0];
  assign new_dec   = decode_cmd(cmd_byte);

  assign cmd_done     = (phase_q == PH_CMD)   && sclk_rise && (cnt_nxt == CNT_W'(8));
  assign addr_done    = (phase_q == PH_ADDR)  && sclk_rise && (cnt_nxt == CNT_W'(ADDR_W));
  assign byte_in_done = (phase_q == PH_RXD)   && sclk_rise && (cnt_nxt == CNT_W'(8));
  assign dummy_done   = (phase_q == PH_DUMMY) && sclk_rise && (cnt_nxt == CNT_W'(DUMMY_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      dec_q      <= '0;
      sh_q       <= '0;
      cnt_q      <= '0;
      last_cmd_o <= '0;
      cmd_irq_o  <= 1'b0;
      addr_o     <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      cmd_irq_o  <= 1'b0;
      rx_valid_o <= 1'b0;
      if (csn_s) begin
        phase_q <= PH_IDLE;
        cnt_q   <= '0;
      end else begin
        case (phase_q)
          PH_IDLE: begin
            phase_q <= PH_CMD;
            cnt_q   <= '0;
          end
          PH_CMD: if (sclk_rise) begin
            sh_q  <= shift_nxt;
            cnt_q <= cnt_nxt;
            if (cmd_done) begin
              last_cmd_o <= cmd_byte;
              cmd_irq_o  <= 1'b1;
              dec_q      <= new_dec;
              cnt_q      <= '0;
              case (new_dec.kind)
                K_STATUS: phase_q <= PH_TXD;
                K_SILENT: phase_q <= PH_HALT;
                default:  phase_q <= PH_ADDR;
              endcase
            end
          end
          PH_ADDR: if (sclk_rise) begin
            sh_q  <= shift_nxt;
            cnt_q <= cnt_nxt;
            if (addr_done) begin
              addr_o <= shift_nxt[ADDR_W-1:0];
              cnt_q  <= '0;
              if (dec_q.kind == K_WRITE)                    phase_q <= PH_RXD;
              else if (dec_q.dummy && (DUMMY_CYCLES > 0))   phase_q <= PH_DUMMY;
              else                                          phase_q <= PH_TXD;
            end
          end
          PH_DUMMY: if (sclk_rise) begin
            cnt_q <= cnt_nxt;
            if (dummy_done) begin
              cnt_q   <= '0;
              phase_q <= PH_TXD;
            end
          end
          PH_RXD: if (sclk_rise) begin
            sh_q  <= shift_nxt;
            cnt_q <= cnt_nxt;
            if (byte_in_done) begin
              rx_data_o  <= shift_nxt[7:0];
              rx_valid_o <= 1'b1;
              cnt_q      <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Read / status output path
  logic       tx_active, tx_load;
  logic [7:0] tx_next;

  assign tx_active = (phase_q == PH_TXD);
  assign tx_next   = (dec_q.kind == K_STATUS) ? status_byte(ready_i) : tx_data_i;

  spi_tx_serializer u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (csn_s | ~tx_active),
    .active    (tx_active),
    .fall      (sclk_fall),
    .dual      (dec_q.dual_data),
    .next_byte (tx_next),
    .io_out    (spi_io_o),
    .io_oe     (spi_io_oe_o),
    .load      (tx_load)
  );

  assign tx_pop_o = tx_load & (dec_q.kind == K_READ);

  AST_CSN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (spi_io_oe_o == 2'b00)); // R10
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_irq_o |=> !cmd_irq_o); // R2
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_irq_o |-> $stable(last_cmd_o)); // R2
  AST_POP_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_o |-> (dec_q.kind == K_READ)); // R3
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HALT) |-> (!rx_valid_o && !tx_pop_o && spi_io_oe_o == 2'b00)); // R9
  AST_RX_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> (dec_q.kind == K_WRITE)); // R7
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid_o, tx_pop_o, cmd_irq_o})); // R7
endmodule

// File: tb/spi_cmd_slave_test.sv
`timescale 1ns/1ps
module spi_cmd_slave_test;
  localparam int AW = 16;
  localparam int H  = 6;     // clocks per SCLK half period

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sclk = 1'b0, csn = 1'b1;
  logic [1:0]    io_in = 2'b00;
  logic [1:0]    io_out, io_oe;
  logic          ready = 1'b0;
  logic [7:0]    last_cmd, rx_data;
  logic          cmd_irq, rx_valid, tx_pop;
  logic [AW-1:0] addr;
  logic [7:0]    tx_data;

  always #10 clk = ~clk;   // 50 MHz

  spi_cmd_slave #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk_i(sclk), .spi_csn_i(csn),
    .spi_io_i(io_in), .spi_io_o(io_out), .spi_io_oe_o(io_oe),
    .ready_i(ready), .last_cmd_o(last_cmd), .cmd_irq_o(cmd_irq),
    .addr_o(addr), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .tx_data_i(tx_data), .tx_pop_o(tx_pop)
  );

  int n_checks = 0, n_fail = 0;
  int tx_idx = 0, pop_cnt = 0, irq_cnt = 0, csn_hi = 0, cycles = 0;
  bit pop_prev = 0, expect_off = 0;
  logic [7:0] cur_cmd = 8'h00;
  logic [7:0] rxq[$];

  function automatic logic [7:0] tx_byte(input int i);
    return 8'(i * 37 + 8'h3C);
  endfunction
  assign tx_data = tx_byte(tx_idx);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural per-clock model, sampled a quarter period after each edge
  always @(posedge clk) begin
    #5;
    cycles++;
    if (pop_prev) tx_idx++;
    pop_prev = tx_pop;
    if (tx_pop) pop_cnt++;
    if (rx_valid) rxq.push_back(rx_data);
    if (cmd_irq) begin
      irq_cnt++;
      chk(last_cmd == cur_cmd, "R2", "last_cmd at pulse", last_cmd, cur_cmd);
    end
    csn_hi = csn ? csn_hi + 1 : 0;
    if (csn_hi >= 3 && io_oe != 2'b00)
      chk(0, "R10", "lane enable after CSn high", io_oe, 0);
    if (expect_off && io_oe != 2'b00)
      chk(0, "R9", "lane enable outside read phase", io_oe, 0);
    if (cycles > 150000) begin
      chk(0, "WDOG", "watchdog expired", cycles, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  task automatic bit_time(input logic [1:0] drv, output logic [1:0] seen);
    sclk  = 1'b0;
    io_in = drv;
    repeat (H) @(negedge clk);
    seen = io_out;
    sclk = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic xfer_byte(input bit dual, input logic [7:0] b, output logic [7:0] rb);
    logic [1:0] s;
    rb = 8'h00;
    if (dual) begin
      for (int i = 7; i > 0; i -= 2) begin
        bit_time({b[i], b[i-1]}, s);
        rb[i] = s[1]; rb[i-1] = s[0];
      end
    end else begin
      for (int i = 7; i >= 0; i--) begin
        bit_time({1'b0, b[i]}, s);
        rb[i] = s[1];
      end
    end
  endtask

  // Bench's own reading of the command set: 0 silent, 1 status, 2 read, 3 write
  task automatic bdecode(input logic [7:0] c, output int kind,
                         output bit da, output bit dd, output bit dm);
    da = 0; dd = 0; dm = 0;
    if (c == 8'h05) kind = 1;
    else if (c == 8'h15) begin kind = 1; dd = 1; end
    else if (c == 8'h25 || c == 8'h0E || c == 8'h54) kind = 0;
    else if (c == 8'h0B) kind = 2;
    else if (c == 8'h0C) begin kind = 2; dd = 1; end
    else if (c == 8'h51) kind = 3;
    else if (c == 8'h52) begin kind = 3; dd = 1; end
    else begin
      kind = c[7] ? 2 : 3;
      da = c[6]; dd = c[5]; dm = c[7] && c[4];
    end
  endtask

  task automatic run_txn(input logic [7:0] cmd, input logic [AW-1:0] a,
                         input int nbytes, input int abort_bits, input string req);
    int kind; bit da, dd, dm;
    logic [7:0] rb, wb;
    logic [1:0] s;
    int irq0, pop0, rx0, idx0;
    logic [AW-1:0] addr0;
    bdecode(cmd, kind, da, dd, dm);
    irq0 = irq_cnt; pop0 = pop_cnt; rx0 = rxq.size(); addr0 = addr;
    cur_cmd = cmd;
    expect_off = 1;
    csn = 1'b0;
    repeat (H) @(negedge clk);
    xfer_byte(0, cmd, rb);
    if (kind == 1) begin
      expect_off = 0;
      for (int k = 0; k < nbytes; k++) begin
        xfer_byte(dd, 8'h00, rb);
        chk(rb == (ready ? 8'h5A : 8'h00), "R3", "status byte", rb, ready ? 8'h5A : 8'h00);
      end
    end else if (kind == 0) begin
      for (int k = 0; k < 24; k++) bit_time(2'b11, s);
    end else begin
      if (da) for (int i = AW-1; i > 0; i -= 2) bit_time({a[i], a[i-1]}, s);
      else    for (int i = AW-1; i >= 0; i--)   bit_time({1'b0, a[i]}, s);
      if (kind == 2 && dm) for (int k = 0; k < 4; k++) bit_time(2'b00, s);
      if (kind == 3) begin
        for (int k = 0; k < nbytes; k++) begin
          wb = 8'(8'hA5 ^ (k * 29 + cmd));
          xfer_byte(dd, wb, rb);
        end
      end else begin
        expect_off = 0;
        @(negedge clk);
        idx0 = tx_idx;
        for (int k = 0; k < nbytes; k++) begin
          xfer_byte(dd, 8'h00, rb);
          chk(rb == tx_byte(idx0 + k), (cmd == 8'h0B || cmd == 8'h0C) ? "R4" : "R8",
              "read byte", rb, tx_byte(idx0 + k));
        end
      end
    end
    if (abort_bits >= 0) begin
      for (int k = 0; k < abort_bits; k++) bit_time(2'b01, s);
      csn = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end else begin
      sclk = 1'b0;
      repeat (H) @(negedge clk);
      csn = 1'b1;
    end
    repeat (3*H) @(negedge clk);
    expect_off = 0;
    chk(irq_cnt == irq0 + 1, "R2", "command pulse count", irq_cnt - irq0, 1);
    chk(last_cmd == cmd, "R2", "last command", last_cmd, cmd);
    if (kind == 1) chk(pop_cnt == pop0, "R3", "no pull on status", pop_cnt - pop0, 0);
    if (kind == 0) begin
      chk(addr == addr0, "R9", "address untouched", addr, addr0);
      chk(rxq.size() == rx0, "R9", "no receive", rxq.size() - rx0, 0);
      chk(pop_cnt == pop0, "R9", "no pull", pop_cnt - pop0, 0);
    end
    if (kind >= 2) chk(addr == a, da ? "R5" : "R6", "address", addr, a);
    if (kind == 2) chk(pop_cnt == pop0 + nbytes + 1, "R8", "pull count", pop_cnt - pop0, nbytes + 1);
    if (kind == 3) begin
      chk(rxq.size() == rx0 + nbytes, (abort_bits >= 0) ? "R10" : "R7",
          "received count", rxq.size() - rx0, nbytes);
      for (int k = 0; k < nbytes && rx0 + k < rxq.size(); k++)
        chk(rxq[rx0 + k] == 8'(8'hA5 ^ (k * 29 + cmd)), dd ? "R5" : "R7", "received byte",
            rxq[rx0 + k], 8'(8'hA5 ^ (k * 29 + cmd)));
    end
    if (req.len() > 0) chk(1, req, "scenario done", 0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(io_oe == 2'b00 && last_cmd == 8'h00 && addr == '0 && rx_data == 8'h00,
        "R1", "reset outputs", {io_oe, last_cmd, rx_data}, 0);
    chk(!cmd_irq && !rx_valid && !tx_pop, "R1", "reset strobes",
        {cmd_irq, rx_valid, tx_pop}, 0);

    ready = 1'b1; run_txn(8'h05, '0, 2, -1, "R3");
    ready = 1'b0; run_txn(8'h15, '0, 2, -1, "R3");
    ready = 1'b1; run_txn(8'h15, '0, 1, -1, "R3");
    run_txn(8'h51, 16'h1234, 3, -1, "R4");
    run_txn(8'h52, 16'hBEEF, 2, -1, "R4");
    run_txn(8'h0B, 16'h00F0, 3, -1, "R4");
    run_txn(8'h0C, 16'h8001, 2, -1, "R4");
    run_txn(8'hE0, 16'hC35A, 2, -1, "R5");
    run_txn(8'h90, 16'h7E81, 2, -1, "R5");
    run_txn(8'h10, 16'h0F0F, 2, -1, "R5");
    run_txn(8'h40, 16'hA5C3, 1, -1, "R6");
    run_txn(8'h25, '0, 0, -1, "R9");
    run_txn(8'h0E, '0, 0, -1, "R9");
    run_txn(8'h51, 16'h2468, 1, 3, "R10");
    ready = 1'b0; run_txn(8'h05, '0, 1, -1, "R10");
    run_txn(8'h0B, 16'h1357, 1, 4, "R10");
    run_txn(8'h52, 16'h9ABC, 1, -1, "R7");

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule